// File: doc/BRIEF.md
# Child fetch merging unit

This unit sits on the memory side, between the block that generates child texel fetches and the memory switch. Each incoming fetch carries a child texel address and the identifier of the parent texel that asked for it. When several parents ask for the same child while a read for that address is still in flight, the unit issues only one memory read. It records every waiting parent in a pairing table.

When the read data comes back, the unit walks the list of parents linked to that read. It produces one delivery per parent, one per cycle. Each delivery carries the parent identifier and the returned child data, in the order the fetches were accepted. The last delivery of a read is flagged so that downstream logic can tell how many parents shared the child.

Memory reads carry a slot tag, and the memory side must echo that tag with the returned data. The unit holds new fetches back when it has no free pairing entry. It also holds them back when the fetch needs a new read and every read slot is taken.

Top module: `child_fetch_merge`

## Requirements
- R1: After reset, `req_ready` and `ret_ready` are high, and `rd_valid` and `dlv_valid` are low.
- R2: A fetch accepted (`req_valid` and `req_ready` high) whose address matches no outstanding read raises `rd_valid` in the same cycle. In that cycle `rd_addr` equals the fetch address and `rd_tag` names a slot not already in flight.
- R3: A fetch accepted while a read for the same address is outstanding, with its data not yet returned, issues no memory read. The fetch is attached to the existing read.
- R4: A return accepted in cycle N (`ret_valid` and `ret_ready` high) produces one delivery per attached parent in cycles N+1, N+2, and so on, with no gaps. The deliveries come in fetch-acceptance order. Each carries `ret_data`, and `dlv_last` is high only on the final one.
- R5: `ret_ready` is low exactly while deliveries for an earlier return are still being produced.
- R6: Once the data for an address has been accepted, a later fetch to that address starts a new memory read, even while deliveries for the old read are still in progress.
- R7: `req_ready` is low when all 256 pairing entries are occupied. It is also low when the fetch misses and all read slots (8 by default) are in flight. A fetch that hits an outstanding read is still accepted when only the slots are exhausted.
- R8: Pairing entries and slots are freed by their deliveries. After every outstanding read has been delivered, the unit again accepts a fetch to a new address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Child fetch present |
| req_ready | output | 1 | Child fetch accepted this cycle when valid |
| req_addr | input | 20 | Child texel address |
| req_pid | input | 8 | Requesting parent identifier |
| rd_valid | output | 1 | Memory read issued this cycle |
| rd_addr | output | 20 | Address of the memory read |
| rd_tag | output | 3 | Slot tag to be echoed on return |
| ret_valid | input | 1 | Read data present |
| ret_ready | output | 1 | Read data accepted this cycle when valid |
| ret_tag | input | 3 | Slot tag of the returned read |
| ret_data | input | 32 | Returned child texel data |
| dlv_valid | output | 1 | Delivery present |
| dlv_pid | output | 8 | Parent identifier of the delivery |
| dlv_data | output | 32 | Child data of the delivery |
| dlv_last | output | 1 | Final delivery for this read |

## Verification
The assertions take for granted that a return only names a tag the unit has issued and whose data has not yet come back. They also assume that `ret_valid` is only raised with a tag that is still live. The stimulus meets this by keeping its own list of issued tags: it returns the oldest of them and removes it from the list on acceptance. The stimulus only raises `ret_valid` when the model expects `ret_ready`, so no return is held across cycles. Addresses are drawn from small sets, so that merging, slot exhaustion and reissue after draining all occur often.

// File: rtl/cfm_pkg.sv
package cfm_pkg;

    localparam int CFM_ADDR_W = 20;
    localparam int CFM_PID_W  = 8;
    localparam int CFM_DATA_W = 32;
    localparam int CFM_NSLOT  = 8;
    localparam int CFM_NPAIR  = 256;

    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_RUN  = 1'b1
    } walk_state_e;

endpackage

// File: rtl/cfm_addr_cam.sv
module cfm_addr_cam #(
    parameter int ADDR_W = 20,
    parameter int NSLOT  = 8,
    parameter int PIDX_W = 8,
    localparam int SLOT_W = $clog2(NSLOT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              hit,
    output logic [SLOT_W-1:0] hit_slot,
    output logic [PIDX_W-1:0] hit_tail,
    output logic              free_ok,
    output logic [SLOT_W-1:0] free_slot,
    input  logic              alloc_en,
    input  logic [PIDX_W-1:0] alloc_idx,
    input  logic              append_en,
    input  logic [PIDX_W-1:0] append_idx,
    input  logic              drain_en,
    input  logic [SLOT_W-1:0] drain_slot,
    input  logic              release_en,
    input  logic [SLOT_W-1:0] release_slot,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [PIDX_W-1:0] rd_head,
    output logic [PIDX_W-1:0] rd_tail
);

    logic [NSLOT-1:0]  vld;
    logic [NSLOT-1:0]  drn;
    logic [NSLOT-1:0]  match;
    logic [ADDR_W-1:0] adr [NSLOT];
    logic [PIDX_W-1:0] hd  [NSLOT];
    logic [PIDX_W-1:0] tl  [NSLOT];

    for (genvar s = 0; s < NSLOT; s++) begin : g_cmp
        assign match[s] = vld[s] && !drn[s] && (adr[s] == lk_addr);
    end

    always_comb begin
        hit       = |match;
        hit_slot  = '0;
        free_ok   = 1'b0;
        free_slot = '0;
        for (int s = 0; s < NSLOT; s++) begin
            if (match[s]) hit_slot = SLOT_W'(s);
        end
        for (int s = NSLOT - 1; s >= 0; s--) begin
            if (!vld[s]) begin
                free_ok   = 1'b1;
                free_slot = SLOT_W'(s);
            end
        end
    end

    assign hit_tail = tl[hit_slot];
    assign rd_head  = hd[rd_slot];
    assign rd_tail  = tl[rd_slot];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
            drn <= '0;
        end else begin
            if (release_en) vld[release_slot] <= 1'b0;
            if (drain_en)   drn[drain_slot]   <= 1'b1;
            if (alloc_en) begin
                vld[free_slot] <= 1'b1;
                drn[free_slot] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (alloc_en) begin
            adr[free_slot] <= lk_addr;
            hd[free_slot]  <= alloc_idx;
            tl[free_slot]  <= alloc_idx;
        end
        if (append_en) tl[hit_slot] <= append_idx;
    end

    // R3
    single_match_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match));

    // R4
    ret_tag_live_chk: assert property (@(posedge clk) disable iff (rst)
        drain_en |-> (vld[drain_slot] && !drn[drain_slot]));

    // R4
    release_drained_chk: assert property (@(posedge clk) disable iff (rst)
        release_en |-> (vld[release_slot] && drn[release_slot]));

endmodule

// File: rtl/cfm_pair_pool.sv
module cfm_pair_pool #(
    parameter int NPAIR = 256,
    parameter int PID_W = 8,
    localparam int PIDX_W = $clog2(NPAIR),
    localparam int CNT_W  = PIDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    output logic              avail,
    input  logic              pop_en,
    output logic [PIDX_W-1:0] pop_idx,
    input  logic [PID_W-1:0]  wr_pid,
    input  logic              link_en,
    input  logic [PIDX_W-1:0] link_from,
    input  logic              push_en,
    input  logic [PIDX_W-1:0] push_idx,
    input  logic [PIDX_W-1:0] rd_idx,
    output logic [PID_W-1:0]  rd_pid,
    output logic [PIDX_W-1:0] rd_next
);

    logic [PIDX_W-1:0] stk   [NPAIR];
    logic [PID_W-1:0]  pid_m [NPAIR];
    logic [PIDX_W-1:0] nxt_m [NPAIR];
    logic [CNT_W-1:0]  cnt;
    logic [PIDX_W-1:0] top;

    assign avail   = (cnt != '0);
    assign top     = PIDX_W'(cnt - 1'b1);
    assign pop_idx = stk[top];
    assign rd_pid  = pid_m[rd_idx];
    assign rd_next = nxt_m[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= CNT_W'(NPAIR);
            for (int i = 0; i < NPAIR; i++) stk[i] <= PIDX_W'(i);
        end else begin
            case ({pop_en, push_en})
                2'b11:   stk[top] <= push_idx;
                2'b01: begin
                    stk[cnt[PIDX_W-1:0]] <= push_idx;
                    cnt <= cnt + 1'b1;
                end
                2'b10:   cnt <= cnt - 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (pop_en)  pid_m[pop_idx]   <= wr_pid;
        if (link_en) nxt_m[link_from] <= pop_idx;
    end

    // R7
    pool_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        pop_en |-> avail);

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (push_en && !pop_en) |-> (cnt < CNT_W'(NPAIR)));

endmodule

// File: rtl/child_fetch_merge.sv
module child_fetch_merge
    import cfm_pkg::*;
#(
    parameter int ADDR_W = CFM_ADDR_W,
    parameter int PID_W  = CFM_PID_W,
    parameter int DATA_W = CFM_DATA_W,
    parameter int NSLOT  = CFM_NSLOT,
    parameter int NPAIR  = CFM_NPAIR,
    localparam int SLOT_W = $clog2(NSLOT),
    localparam int PIDX_W = $clog2(NPAIR)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [PID_W-1:0]  req_pid,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [SLOT_W-1:0] rd_tag,
    input  logic              ret_valid,
    output logic              ret_ready,
    input  logic [SLOT_W-1:0] ret_tag,
    input  logic [DATA_W-1:0] ret_data,
    output logic              dlv_valid,
    output logic [PID_W-1:0]  dlv_pid,
    output logic [DATA_W-1:0] dlv_data,
    output logic              dlv_last
);

    logic              hit, free_ok, pool_avail, acc, ret_acc, walking;
    logic [SLOT_W-1:0] hit_slot, free_slot, cam_rd_slot;
    logic [PIDX_W-1:0] hit_tail, new_idx, head_q, tail_q, next_q;
    walk_state_e       w_state;
    logic [SLOT_W-1:0] w_slot;
    logic [PIDX_W-1:0] w_cur;
    logic [DATA_W-1:0] w_data;

    assign walking     = (w_state == WALK_RUN);
    assign req_ready   = pool_avail && (hit || free_ok);
    assign acc         = req_valid && req_ready;
    assign ret_ready   = !walking;
    assign ret_acc     = ret_valid && ret_ready;
    assign rd_valid    = acc && !hit;
    assign rd_addr     = req_addr;
    assign rd_tag      = free_slot;
    assign cam_rd_slot = walking ? w_slot : ret_tag;
    assign dlv_valid   = walking;
    assign dlv_data    = w_data;
    assign dlv_last    = walking && (w_cur == tail_q);

    cfm_addr_cam #(.ADDR_W(ADDR_W), .NSLOT(NSLOT), .PIDX_W(PIDX_W)) cam_i (
        .clk          (clk),
        .rst          (rst),
        .lk_addr      (req_addr),
        .hit          (hit),
        .hit_slot     (hit_slot),
        .hit_tail     (hit_tail),
        .free_ok      (free_ok),
        .free_slot    (free_slot),
        .alloc_en     (acc && !hit),
        .alloc_idx    (new_idx),
        .append_en    (acc && hit),
        .append_idx   (new_idx),
        .drain_en     (ret_acc),
        .drain_slot   (ret_tag),
        .release_en   (dlv_last),
        .release_slot (w_slot),
        .rd_slot      (cam_rd_slot),
        .rd_head      (head_q),
        .rd_tail      (tail_q)
    );

    cfm_pair_pool #(.NPAIR(NPAIR), .PID_W(PID_W)) pool_i (
        .clk       (clk),
        .rst       (rst),
        .avail     (pool_avail),
        .pop_en    (acc),
        .pop_idx   (new_idx),
        .wr_pid    (req_pid),
        .link_en   (acc && hit),
        .link_from (hit_tail),
        .push_en   (walking),
        .push_idx  (w_cur),
        .rd_idx    (w_cur),
        .rd_pid    (dlv_pid),
        .rd_next   (next_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            w_state <= WALK_IDLE;
            w_slot  <= '0;
            w_cur   <= '0;
            w_data  <= '0;
        end else if (!walking) begin
            if (ret_valid) begin
                w_state <= WALK_RUN;
                w_slot  <= ret_tag;
                w_cur   <= head_q;
                w_data  <= ret_data;
            end
        end else if (dlv_last) begin
            w_state <= WALK_IDLE;
        end else begin
            w_cur <= next_q;
        end
    end

    // R4
    deliver_start_chk: assert property (@(posedge clk) disable iff (rst)
        ret_acc |=> (dlv_valid && dlv_data == $past(ret_data)));

    // R4
    walk_continue_chk: assert property (@(posedge clk) disable iff (rst)
        (dlv_valid && !dlv_last) |=> (dlv_valid && $stable(dlv_data)));

endmodule

// File: tb/child_fetch_merge_tb_top.sv
module child_fetch_merge_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NSLOT = 8;
    localparam int NPAIR = 256;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [19:0] req_addr = '0;
    logic [7:0]  req_pid = '0;
    logic        rd_valid;
    logic [19:0] rd_addr;
    logic [2:0]  rd_tag;
    logic        ret_valid = 1'b0;
    logic        ret_ready;
    logic [2:0]  ret_tag = '0;
    logic [31:0] ret_data = '0;
    logic        dlv_valid;
    logic [7:0]  dlv_pid;
    logic [31:0] dlv_data;
    logic        dlv_last;

    always #(CLK_PERIOD / 2) clk = ~clk;

    child_fetch_merge dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_pid(req_pid),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_tag(rd_tag),
        .ret_valid(ret_valid), .ret_ready(ret_ready), .ret_tag(ret_tag), .ret_data(ret_data),
        .dlv_valid(dlv_valid), .dlv_pid(dlv_pid), .dlv_data(dlv_data), .dlv_last(dlv_last)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    // behavioural reference state
    int          slots_used = 0;
    int          pairs_used = 0;
    bit          m_valid [NSLOT];
    bit          m_drain [NSLOT];
    logic [19:0] m_addr  [NSLOT];
    int          pq[$];
    int          dq_pid[$];
    int          dq_tag[$];
    bit          dq_last[$];
    logic [31:0] dq_data[$];
    int          pend[$];

    function automatic logic [31:0] data_of(input logic [19:0] a);
        return (32'(a) * 32'd2654435761) ^ 32'hC3A5_0F1E;
    endfunction

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int find_hit(input logic [19:0] a);
        for (int t = 0; t < NSLOT; t++)
            if (m_valid[t] && !m_drain[t] && m_addr[t] == a) return t;
        return -1;
    endfunction

    // compare the DUT against the model for this cycle, then commit the model
    task automatic step();
        int  ht;
        bit  e_ready, e_acc, e_rd, e_retrdy;
        #1;
        ht       = find_hit(req_addr);
        e_ready  = (pairs_used < NPAIR) && (ht >= 0 || slots_used < NSLOT);
        e_acc    = req_valid && e_ready;
        e_rd     = e_acc && (ht < 0);
        e_retrdy = (dq_pid.size() == 0);
        chk(64'(req_ready), 64'(e_ready), "R7", "req_ready");
        chk(64'(rd_valid), 64'(e_rd), e_rd ? "R2" : "R3", "rd_valid");
        if (e_rd && rd_valid) chk(64'(rd_addr), 64'(req_addr), "R2", "rd_addr");
        chk(64'(ret_ready), 64'(e_retrdy), "R5", "ret_ready");
        chk(64'(dlv_valid), 64'(!e_retrdy), "R4", "dlv_valid");
        if (!e_retrdy) begin
            chk(64'(dlv_pid), 64'(dq_pid[0]), "R4", "dlv_pid");
            chk(64'(dlv_data), 64'(dq_data[0]), "R4", "dlv_data");
            chk(64'(dlv_last), 64'(dq_last[0]), "R4", "dlv_last");
        end
        // deliveries free their resources
        if (!e_retrdy) begin
            pairs_used--;
            if (dq_last[0]) begin
                m_valid[dq_tag[0]] = 1'b0;
                slots_used--;
            end
            void'(dq_pid.pop_front());
            void'(dq_tag.pop_front());
            void'(dq_last.pop_front());
            void'(dq_data.pop_front());
        end
        // accept a fetch
        if (e_acc) begin
            pairs_used++;
            if (ht >= 0) begin
                pq.push_back(ht * 256 + int'(req_pid));
            end else if (rd_valid) begin
                m_valid[rd_tag] = 1'b1;
                m_drain[rd_tag] = 1'b0;
                m_addr[rd_tag]  = req_addr;
                slots_used++;
                pq.push_back(int'(rd_tag) * 256 + int'(req_pid));
                pend.push_back(int'(rd_tag));
            end
        end
        // accept a return
        if (ret_valid && e_retrdy) begin
            int keep[$];
            int sel[$];
            m_drain[ret_tag] = 1'b1;
            foreach (pq[i]) begin
                if (pq[i] / 256 == int'(ret_tag)) sel.push_back(pq[i]);
                else keep.push_back(pq[i]);
            end
            pq = keep;
            foreach (sel[i]) begin
                dq_pid.push_back(sel[i] % 256);
                dq_tag.push_back(int'(ret_tag));
                dq_data.push_back(ret_data);
                dq_last.push_back(i == sel.size() - 1);
            end
            foreach (pend[i]) begin
                if (pend[i] == int'(ret_tag)) begin
                    pend.delete(i);
                    break;
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cyc(input bit v, input logic [19:0] a, input logic [7:0] p, input bit rv);
        req_valid = v;
        req_addr  = a;
        req_pid   = p;
        if (rv && pend.size() > 0 && dq_pid.size() == 0) begin
            ret_valid = 1'b1;
            ret_tag   = 3'(pend[0]);
            ret_data  = data_of(m_addr[pend[0]]);
        end else begin
            ret_valid = 1'b0;
        end
        step();
    endtask

    task automatic drain_all();
        while (pend.size() > 0 || dq_pid.size() > 0) cyc(1'b0, 20'd0, 8'd0, 1'b1);
    endtask

    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 150000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int t = 0; t < NSLOT; t++) begin
            m_valid[t] = 1'b0;
            m_drain[t] = 1'b0;
            m_addr[t]  = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk(64'(req_ready), 64'd1, "R1", "req_ready after reset");
        chk(64'(ret_ready), 64'd1, "R1", "ret_ready after reset");
        chk(64'(rd_valid), 64'd0, "R1", "rd_valid after reset");
        chk(64'(dlv_valid), 64'd0, "R1", "dlv_valid after reset");

        // single fetch, then return
        cyc(1'b1, 20'h00010, 8'h11, 1'b0);
        cyc(1'b0, 20'h0, 8'h0, 1'b1);
        drain_all();

        // three parents merge onto one address, plus another address
        cyc(1'b1, 20'h00020, 8'h21, 1'b0);
        cyc(1'b1, 20'h00030, 8'h31, 1'b0);
        cyc(1'b1, 20'h00020, 8'h22, 1'b0);
        cyc(1'b1, 20'h00020, 8'h23, 1'b0);
        cyc(1'b0, 20'h0, 8'h0, 1'b1);
        // R6: data for 0x20 accepted, so a new fetch must start a new read
        req_valid = 1'b1; req_addr = 20'h00020; req_pid = 8'h24; ret_valid = 1'b0;
        #1;
        chk(64'(rd_valid), 64'd1, "R6", "reissue after return");
        step();
        drain_all();

        // R7: slots exhausted by distinct misses, hits still accepted
        for (int i = 0; i < NSLOT; i++) cyc(1'b1, 20'(20'h00100 + i), 8'(i), 1'b0);
        req_valid = 1'b1; req_addr = 20'h00200; req_pid = 8'h55; ret_valid = 1'b0;
        #1;
        chk(64'(req_ready), 64'd0, "R7", "miss with all slots busy");
        step();
        req_addr = 20'h00103;
        #1;
        chk(64'(req_ready), 64'd1, "R7", "hit with all slots busy");
        step();
        drain_all();

        // R7: pair table exhausted
        for (int i = 0; i < NPAIR; i++) cyc(1'b1, 20'(20'h00300 + (i % NSLOT)), 8'(i), 1'b0);
        req_valid = 1'b1; req_addr = 20'h00301; req_pid = 8'hEE; ret_valid = 1'b0;
        #1;
        chk(64'(req_ready), 64'd0, "R7", "hit with pair table full");
        step();
        drain_all();
        // R8: resources came back
        req_valid = 1'b1; req_addr = 20'h00400; req_pid = 8'h01; ret_valid = 1'b0;
        #1;
        chk(64'(req_ready), 64'd1, "R8", "ready after full drain");
        chk(64'(rd_valid), 64'd1, "R8", "read after full drain");
        step();
        drain_all();

        // random mix over a small address set
        for (int i = 0; i < 4000; i++)
            cyc(1'($urandom % 2), 20'(20'h00500 + ($urandom % 10)), 8'($urandom), ($urandom % 4) == 0);
        drain_all();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule